// File: doc/BRIEF.md
# Flash Block-Transfer DMA Engine

This engine copies a block of 32-bit words between system memory and the data buffer of a flash controller, one block per command. Software loads a memory address, a flash-side address and a byte length through a small 32-bit register window. It then writes a direction code to the command register, and the engine moves the words one handshake at a time. For each word it first fetches from the source port and then stores to the destination port.

When the block has been moved, the engine sets bits in a completion register and raises an interrupt line. That line stays high until software clears the register. An error acknowledge from the memory side ends the transfer early and is remembered in a sticky fault bit. A write to the halt register drops any transfer in flight. Longer buffers are moved by software, which re-arms the engine chunk by chunk and advances both addresses between commands. An optional mode reverses the byte order of every word that passes through.

Top module: `blk_xfer_dma`

## Requirements
- R1: After reset every register reads zero, the interrupt is low and neither port presents a request.
- R2: Register words are decoded from reg_addr[5:2], with reg_addr[1:0] equal to zero: 0 config, 1 memory address, 2 flash address, 3 byte length, 4 command, 5 halt, 6 status, 7 completion, 8 fault. Config keeps bits [1:0]. The memory address, flash address and length read back as written. Halt and unmapped words read zero.
- R3: Command bit 0 equal to 0 moves length/4 words from memory to flash. Word k is read from memory at the memory address plus 4k and is then written to flash at the flash address plus 4k, in ascending order. No other location is written.
- R4: Command bit 0 equal to 1 moves length/4 words from flash to memory, using the same address stepping.
- R5: Status bit 0 reads 1 from the cycle after an accepted command write until the cycle after the last store handshake, and 0 otherwise.
- R6: A normal completion sets completion bit 0. The interrupt is high whenever completion bits [1:0] are nonzero, and any write to the completion register clears both bits.
- R7: With config bit 1 set, every word is stored with its four bytes in reversed order (byte 0 swapped with byte 3, byte 1 with byte 2).
- R8: A command write while status bit 0 is 1 is ignored: the transfer in flight and the command readback are unaffected.
- R9: Any write to the halt register ends an active transfer within one cycle. It sets no completion bit, and no further port request follows.
- R10: An error acknowledge on a memory handshake ends the transfer at once. No store is made for that word. The engine sets fault bit 0 and completion bit 1, and status bit 0 clears. The fault bit stays set across later transfers until software writes the fault register.
- R11: A command with a length below 4 completes in the next cycle with completion bit 0 and makes no port request.
- R12: Writes to the address and length registers during a transfer do not alter it; the engine uses the values held when the command was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Completion interrupt |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_err | input | 1 | Error acknowledge, valid with mem_ready |
| fl_valid | output | 1 | Flash buffer request valid |
| fl_we | output | 1 | Flash buffer request is a write |
| fl_addr | output | AW | Flash buffer byte address |
| fl_wdata | output | 32 | Flash buffer write data |
| fl_ready | input | 1 | Flash buffer accepts the request |
| fl_rdata | input | 32 | Flash buffer read data, valid with fl_ready |

## Verification
The bench aims at the boundaries of a block. It places an error acknowledge on the third fetch and checks that the words before it landed and the word after it did not. An engine that stored the faulted word, or kept running, would corrupt a neighbouring location.

It tries to disturb a stalled transfer in two ways. It issues a second command, which would reverse the direction if accepted. It rewrites the address and length registers, which would relocate the block or cut it short if the engine read them live.

A halt in mid-transfer must leave the completion register clear and the ports silent. A zero-length command must finish without a single request. A design that counted words down before checking for zero would instead sweep the whole address space.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2
    } seq_st_e;

    // register word indices (reg_addr[5:2])
    localparam int REG_CFG   = 0;
    localparam int REG_MADDR = 1;
    localparam int REG_FADDR = 2;
    localparam int REG_LEN   = 3;
    localparam int REG_CMD   = 4;
    localparam int REG_HALT  = 5;
    localparam int REG_STAT  = 6;
    localparam int REG_DONE  = 7;
    localparam int REG_FAULT = 8;

    // command bit 0: direction
    localparam logic DIR_TO_FLASH = 1'b0;
    localparam logic DIR_TO_MEM   = 1'b1;

endpackage

// File: rtl/word_swap.sv
module word_swap #(
    parameter int W = 32
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int BYTES = W / 8;

    logic [W-1:0] rev;

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign rev[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
    end

    assign dout = en ? rev : din;
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                stop,
    input  logic                dir,
    input  logic                swap_en,
    input  logic [AW-1:0]       mem_base,
    input  logic [AW-1:0]       fl_base,
    input  logic [LEN_W-3:0]    words,
    output logic                busy,
    output logic                done_evt,
    output logic                err_evt,
    output logic                mem_valid,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [31:0]         mem_wdata,
    input  logic                mem_ready,
    input  logic [31:0]         mem_rdata,
    input  logic                mem_err,
    output logic                fl_valid,
    output logic                fl_we,
    output logic [AW-1:0]       fl_addr,
    output logic [31:0]         fl_wdata,
    input  logic                fl_ready,
    input  logic [31:0]         fl_rdata
);
    localparam int WORD_W = LEN_W - 2;

    typedef struct packed {
        seq_st_e            st;
        logic               dir;
        logic [AW-1:0]      maddr;
        logic [AW-1:0]      faddr;
        logic [WORD_W-1:0]  left;
        logic [31:0]        data;
    } seq_s;

    seq_s s_q, s_d;

    logic [31:0] src_data, src_swapped;
    logic        mem_hs, fl_hs;

    assign src_data = (s_q.dir == DIR_TO_MEM) ? fl_rdata : mem_rdata;

    word_swap #(.W(32)) u_swap (
        .en   (swap_en),
        .din  (src_data),
        .dout (src_swapped)
    );

    assign busy      = (s_q.st != ST_IDLE);
    assign mem_valid = ((s_q.st == ST_FETCH) && (s_q.dir == DIR_TO_FLASH)) ||
                       ((s_q.st == ST_STORE) && (s_q.dir == DIR_TO_MEM));
    assign fl_valid  = ((s_q.st == ST_FETCH) && (s_q.dir == DIR_TO_MEM)) ||
                       ((s_q.st == ST_STORE) && (s_q.dir == DIR_TO_FLASH));
    assign mem_we    = (s_q.st == ST_STORE);
    assign fl_we     = (s_q.st == ST_STORE);
    assign mem_addr  = s_q.maddr;
    assign fl_addr   = s_q.faddr;
    assign mem_wdata = s_q.data;
    assign fl_wdata  = s_q.data;
    assign mem_hs    = mem_valid && mem_ready;
    assign fl_hs     = fl_valid && fl_ready;

    always_comb begin
        s_d      = s_q;
        done_evt = 1'b0;
        err_evt  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.dir   = dir;
                    s_d.maddr = mem_base;
                    s_d.faddr = fl_base;
                    s_d.left  = words;
                    if (words == '0) done_evt = 1'b1;
                    else             s_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_hs && mem_err) begin
                    err_evt = 1'b1;
                    s_d.st  = ST_IDLE;
                end else if (mem_hs || fl_hs) begin
                    s_d.data = src_swapped;
                    s_d.st   = ST_STORE;
                end
            end
            ST_STORE: begin
                if (mem_hs && mem_err) begin
                    err_evt = 1'b1;
                    s_d.st  = ST_IDLE;
                end else if (mem_hs || fl_hs) begin
                    s_d.maddr = s_q.maddr + AW'(4);
                    s_d.faddr = s_q.faddr + AW'(4);
                    s_d.left  = s_q.left - WORD_W'(1);
                    if (s_q.left == WORD_W'(1)) begin
                        done_evt = 1'b1;
                        s_d.st   = ST_IDLE;
                    end else begin
                        s_d.st   = ST_FETCH;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (stop) begin
            s_d.st   = ST_IDLE;
            done_evt = 1'b0;
            err_evt  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && fl_valid)); // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && !stop) |=> (mem_valid && $stable(mem_addr))); // R3
    AST_HALT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!busy && !mem_valid && !fl_valid)); // R9
    AST_END_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt || err_evt) |=> !busy); // R5
endmodule

// File: rtl/blk_xfer_dma.sv
module blk_xfer_dma
    import dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16,
    parameter int RA_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq,
    output logic             mem_valid,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ready,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_err,
    output logic             fl_valid,
    output logic             fl_we,
    output logic [AW-1:0]    fl_addr,
    output logic [31:0]      fl_wdata,
    input  logic             fl_ready,
    input  logic [31:0]      fl_rdata
);
    localparam int IDX_W = RA_W - 2;

    typedef struct packed {
        logic [1:0]        cfg;
        logic [AW-1:0]     maddr;
        logic [AW-1:0]     faddr;
        logic [LEN_W-1:0]  len;
        logic              cmd;
        logic [1:0]        done;
        logic              fault;
    } regs_s;

    regs_s r_q, r_d;

    logic             hit;
    int               idx;
    logic             wr_cfg, wr_maddr, wr_faddr, wr_len, wr_cmd, wr_halt, wr_done, wr_fault;
    logic             start, busy, done_evt, err_evt;
    logic [IDX_W-1:0] idx_bits;

    assign idx_bits = reg_addr[RA_W-1:2];
    assign idx      = int'(idx_bits);
    assign hit      = reg_we && (reg_addr[1:0] == 2'b00);
    assign wr_cfg   = hit && (idx == REG_CFG);
    assign wr_maddr = hit && (idx == REG_MADDR);
    assign wr_faddr = hit && (idx == REG_FADDR);
    assign wr_len   = hit && (idx == REG_LEN);
    assign wr_cmd   = hit && (idx == REG_CMD);
    assign wr_halt  = hit && (idx == REG_HALT);
    assign wr_done  = hit && (idx == REG_DONE);
    assign wr_fault = hit && (idx == REG_FAULT);
    assign start    = wr_cmd && !busy;

    xfer_seq #(.AW(AW), .LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (wr_halt),
        .dir       (reg_wdata[0]),
        .swap_en   (r_q.cfg[1]),
        .mem_base  (r_q.maddr),
        .fl_base   (r_q.faddr),
        .words     (r_q.len[LEN_W-1:2]),
        .busy      (busy),
        .done_evt  (done_evt),
        .err_evt   (err_evt),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .mem_err   (mem_err),
        .fl_valid  (fl_valid),
        .fl_we     (fl_we),
        .fl_addr   (fl_addr),
        .fl_wdata  (fl_wdata),
        .fl_ready  (fl_ready),
        .fl_rdata  (fl_rdata)
    );

    always_comb begin
        r_d = r_q;
        if (wr_cfg)   r_d.cfg   = reg_wdata[1:0];
        if (wr_maddr) r_d.maddr = reg_wdata[AW-1:0];
        if (wr_faddr) r_d.faddr = reg_wdata[AW-1:0];
        if (wr_len)   r_d.len   = reg_wdata[LEN_W-1:0];
        if (start)    r_d.cmd   = reg_wdata[0];
        if (wr_done)  r_d.done  = 2'b00;
        if (wr_fault) r_d.fault = 1'b0;
        if (done_evt) r_d.done  = r_d.done | 2'b01;
        if (err_evt) begin
            r_d.done  = r_d.done | 2'b10;
            r_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[1:0] == 2'b00) begin
            case (idx)
                REG_CFG:   reg_rdata = {30'd0, r_q.cfg};
                REG_MADDR: reg_rdata = 32'(r_q.maddr);
                REG_FADDR: reg_rdata = 32'(r_q.faddr);
                REG_LEN:   reg_rdata = 32'(r_q.len);
                REG_CMD:   reg_rdata = {31'd0, r_q.cmd};
                REG_STAT:  reg_rdata = {31'd0, busy};
                REG_DONE:  reg_rdata = {30'd0, r_q.done};
                REG_FAULT: reg_rdata = {31'd0, r_q.fault};
                default:   reg_rdata = '0;
            endcase
        end
    end

    assign irq = |r_q.done;

    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> irq); // R6
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fault && !wr_fault) |=> r_q.fault); // R10
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> (!busy && irq)); // R10
    AST_BUSY_CMD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_cmd && !wr_halt && !done_evt && !err_evt) |=> busy); // R8
endmodule

// File: tb/blk_xfer_dma_test.sv
module blk_xfer_dma_test;
    localparam logic [31:0] MS = 32'hA000_0000;
    localparam logic [31:0] FS = 32'h5000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_valid, mem_we, mem_ready, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        fl_valid, fl_we, fl_ready;
    logic [31:0] fl_addr, fl_wdata, fl_rdata;

    logic [31:0] mem_arr [64];
    logic [31:0] fl_arr  [64];
    logic        fill_go = 1'b0;
    logic        stall_on = 1'b0;
    logic        err_on = 1'b0;
    logic [31:0] err_addr = '0;
    logic        tick = 1'b0;
    int          act_cnt = 0;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    blk_xfer_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .fl_valid(fl_valid), .fl_we(fl_we),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_ready(fl_ready),
        .fl_rdata(fl_rdata)
    );

    assign mem_ready = mem_valid && !(stall_on && tick);
    assign fl_ready  = fl_valid && !(stall_on && tick);
    assign mem_rdata = mem_arr[mem_addr[7:2]];
    assign fl_rdata  = fl_arr[fl_addr[7:2]];
    assign mem_err   = err_on && (mem_addr == err_addr);

    always @(posedge clk) begin
        tick <= ~tick;
        if (mem_valid || fl_valid) act_cnt <= act_cnt + 1;
        if (fill_go) begin
            for (int i = 0; i < 64; i++) begin
                mem_arr[i] <= MS + 32'(i);
                fl_arr[i]  <= FS + 32'(i);
            end
        end else begin
            if (mem_valid && mem_ready && mem_we && !mem_err)
                mem_arr[mem_addr[7:2]] <= mem_wdata;
            if (fl_valid && fl_ready && fl_we)
                fl_arr[fl_addr[7:2]] <= fl_wdata;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'(idx * 4); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        reg_addr = 6'(idx * 4);
        #1 d = reg_rdata;
    endtask

    task automatic fill();
        @(negedge clk); fill_go = 1'b1;
        @(negedge clk); fill_go = 1'b0;
    endtask

    task automatic wait_irq();
        int n = 0;
        while (!irq && n < 500) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 9; i++) begin
            rd(i, v); chk("R1 reg zero", v, 0);
        end
        chk("R1 irq", 32'(irq), 0);
        chk("R1 ports idle", 32'(mem_valid | fl_valid), 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R2 cfg", v, 3);
        wr(0, 1);             rd(0, v); chk("R2 cfg", v, 1);
        wr(1, 32'h1234_5678); rd(1, v); chk("R2 maddr", v, 32'h1234_5678);
        wr(2, 32'h0BAD_F00C); rd(2, v); chk("R2 faddr", v, 32'h0BAD_F00C);
        wr(3, 32'h0000_0ABC); rd(3, v); chk("R2 len", v, 32'h0ABC);
        rd(5, v); chk("R2 halt reads zero", v, 0);
        rd(12, v); chk("R2 unmapped", v, 0);
    endtask

    task automatic t_write();
        logic [31:0] v;
        fill();
        wr(1, 32'h10); wr(2, 32'h20); wr(3, 16);
        wr(4, 0);
        rd(6, v); chk("R5 busy after cmd", v, 1);
        wait_irq();
        rd(6, v); chk("R5 idle at done", v, 0);
        for (int k = 0; k < 4; k++) chk("R3 flash word", fl_arr[8+k], MS + 32'(4+k));
        chk("R3 beyond block", fl_arr[12], FS + 12);
        chk("R3 below block", fl_arr[7], FS + 7);
        rd(7, v); chk("R6 done bit0", v, 1);
        wr(7, 0);
        chk("R6 irq cleared", 32'(irq), 0);
        rd(7, v); chk("R6 done cleared", v, 0);
    endtask

    task automatic t_read();
        logic [31:0] v;
        fill();
        wr(1, 32'h80); wr(2, 32'h0); wr(3, 12);
        wr(4, 1);
        wait_irq();
        for (int k = 0; k < 3; k++) chk("R4 mem word", mem_arr[32+k], FS + 32'(k));
        chk("R4 beyond block", mem_arr[35], MS + 35);
        rd(4, v); chk("R4 cmd readback", v, 1);
        wr(7, 0);
    endtask

    task automatic t_swap();
        fill();
        wr(0, 3);
        wr(1, 32'h4); wr(2, 32'hF0); wr(3, 8);
        wr(4, 0);
        wait_irq();
        chk("R7 swapped", fl_arr[60], 32'h010000A0);
        chk("R7 swapped", fl_arr[61], 32'h020000A0);
        wr(7, 0); wr(0, 1);
    endtask

    task automatic t_busy_cmd();
        logic [31:0] v;
        fill();
        stall_on = 1'b1;
        wr(1, 32'h20); wr(2, 32'hC0); wr(3, 32);
        wr(4, 0);
        wr(4, 1);
        wr(1, 32'h0); wr(2, 32'h0); wr(3, 4);
        rd(4, v); chk("R8 cmd readback kept", v, 0);
        wait_irq();
        for (int k = 0; k < 8; k++) chk("R12 word at latched addr", fl_arr[48+k], MS + 32'(8+k));
        chk("R8 no reverse copy", mem_arr[8], MS + 8);
        chk("R12 no write at new addr", fl_arr[0], FS);
        stall_on = 1'b0;
        wr(7, 0);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        int snap;
        fill();
        stall_on = 1'b1;
        wr(1, 32'h0); wr(2, 32'h40); wr(3, 64);
        wr(4, 0);
        repeat (6) @(negedge clk);
        wr(5, 32'h0);
        rd(6, v); chk("R9 status idle", v, 0);
        rd(7, v); chk("R9 no done", v, 0);
        chk("R9 irq low", 32'(irq), 0);
        snap = act_cnt;
        repeat (8) @(negedge clk);
        chk("R9 no requests", 32'(act_cnt - snap), 0);
        chk("R9 tail untouched", fl_arr[31], FS + 31);
        stall_on = 1'b0;
    endtask

    task automatic t_error();
        logic [31:0] v;
        fill();
        err_on = 1'b1; err_addr = 32'h08;
        wr(1, 32'h0); wr(2, 32'hA0); wr(3, 16);
        wr(4, 0);
        wait_irq();
        chk("R10 word0 moved", fl_arr[40], MS);
        chk("R10 word1 moved", fl_arr[41], MS + 1);
        chk("R10 faulted word not stored", fl_arr[42], FS + 42);
        chk("R10 later word not stored", fl_arr[43], FS + 43);
        rd(7, v); chk("R10 done bit1", v, 2);
        rd(8, v); chk("R10 fault set", v, 1);
        rd(6, v); chk("R10 status idle", v, 0);
        err_on = 1'b0;
        wr(7, 0);
        wr(3, 4); wr(4, 0);
        wait_irq();
        rd(7, v); chk("R10 clean done", v, 1);
        rd(8, v); chk("R10 fault sticky", v, 1);
        wr(8, 0);
        rd(8, v); chk("R10 fault cleared", v, 0);
        wr(7, 0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        int snap;
        wr(3, 0);
        snap = act_cnt;
        wr(4, 0);
        rd(7, v); chk("R11 done next cycle", v, 1);
        rd(6, v); chk("R11 not busy", v, 0);
        repeat (3) @(negedge clk);
        chk("R11 no requests", 32'(act_cnt - snap), 0);
        wr(7, 0);
        wr(3, 3); snap = act_cnt; wr(4, 1);
        rd(7, v); chk("R11 sub-word length", v, 1);
        chk("R11 no requests", 32'(act_cnt - snap), 0);
        wr(7, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_write();
        t_read();
        t_swap();
        t_busy_cmd();
        t_halt();
        t_error();
        t_zero();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule